// File: doc/BRIEF.md
# Hall Pattern Sampling Trigger

This block decides the moment at which the three Hall position inputs of a motor-control timer unit are latched. The raw Hall lines go through a two-flop synchronizer. One of eight trigger sources is chosen by a 3-bit select field. The sources are a change on any synchronized Hall line, events from an auxiliary timer, or main-timer events qualified by the count direction. A selected trigger either fires the sample at once or, when the delay bypass is off, starts a down-counting dead-time delay. The sample is taken when that delay expires.

Each sample stores the synchronized pattern in a current-pattern register and moves the old value into a last-pattern register. A one-cycle strobe marks the sample, and a one-cycle change flag marks a sample that differs from the stored one. Triggers are honoured only while all three channel mode fields select Hall sensor mode. The timers themselves, the compare outputs, the capture modes and the register bus lie outside the block and appear only as input ports.

Top module: `hall_sample_trigger`

## Requirements
- R1: A synchronous active-high reset clears sampleStrobe, patternChange, curPattern, lastPattern and the dead-time counter. An event seen during reset causes no later sample.
- R2: With trigSel = 0, any change of the synchronized Hall lines triggers a sample of the newly synchronized value. hallIn passes two flops before it is used. With any other trigSel value, Hall changes do not trigger.
- R3: A trigger from any source is honoured only while all three 4-bit fields of chanModes (channel i at bits 4i+3..4i) equal 8. Otherwise no sample is taken and curPattern holds.
- R4: trigSel = 1 triggers on auxCmpMatch and trigSel = 2 triggers on auxPeriodMatch. Each ignores the other auxiliary event.
- R5: trigSel = 4 triggers on mainPeriodMatch only while countingDown = 0. trigSel = 5 triggers on mainOneMatch only while countingDown = 1.
- R6: trigSel = 6 triggers on mainCmp0Match only while countingDown = 0. trigSel = 7 triggers on mainCmp0Match only while countingDown = 1.
- R7: trigSel = 3 disables all trigger sources. No event or Hall change causes a sample.
- R8: With delayBypass = 1, sampleStrobe is high in the clock cycle right after the edge at which the trigger is seen.
- R9: With delayBypass = 0 and deadTimeReload = D > 0, sampleStrobe rises D cycles after the bypassed timing. D = 0 behaves as bypass.
- R10: A trigger that arrives while the dead-time counter is running reloads it. Only one sample results, timed from the last trigger.
- R11: On a sample, curPattern takes the synchronized Hall value and lastPattern takes the old curPattern. patternChange is high for that cycle only if the two differ. Outside a sample, both pattern registers hold and patternChange is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hallIn | input | 3 | Asynchronous Hall position lines |
| auxCmpMatch | input | 1 | Auxiliary timer compare-match pulse |
| auxPeriodMatch | input | 1 | Auxiliary timer period-match pulse |
| mainPeriodMatch | input | 1 | Main timer period-match pulse |
| mainOneMatch | input | 1 | Main timer one-match pulse |
| mainCmp0Match | input | 1 | Main timer channel-0 compare-match pulse |
| countingDown | input | 1 | Main timer direction, 1 = down |
| trigSel | input | 3 | Trigger source select |
| delayBypass | input | 1 | 1 skips the dead-time delay |
| chanModes | input | 12 | Three 4-bit channel mode fields |
| deadTimeReload | input | 8 | Dead-time reload value |
| sampleStrobe | output | 1 | One cycle per sample |
| curPattern | output | 3 | Most recent sampled pattern |
| lastPattern | output | 3 | Pattern before the most recent sample |
| patternChange | output | 1 | Sample differed from the stored pattern |

## Verification
The bench offers each trigger source its matching event in the wrong direction, and pairs each auxiliary event with the other auxiliary select. A decoder that ignores direction or swaps sources produces an unexpected strobe that the scoreboard rejects. It counts the exact cycle of the dead-time strobe, and it retriggers mid-count. A counter that is off by one, or one that lets the first trigger expire, strobes in a cycle where the bench expects silence. Resampling an unchanged pattern, and breaking one channel mode field, catch a change flag tied to the strobe and a Hall mode gate that checks only some channels.

// File: rtl/hst_pkg.sv
package hst_pkg;
  typedef struct packed {
    logic capture;
    logic delayed;
  } hstStrobes_t;

  typedef enum logic {
    DT_IDLE = 1'b0,
    DT_COUNT = 1'b1
  } dtState_e;
endpackage

// File: rtl/hst_trig_select.sv
module hst_trig_select #(
  parameter int HALL_W    = 3,
  parameter int MODE_W    = 4,
  parameter int SEL_W     = 3,
  parameter int HALL_MODE = 8
) (
  input  logic                     hallEdge,
  input  logic                     auxCmpMatch,
  input  logic                     auxPeriodMatch,
  input  logic                     mainPeriodMatch,
  input  logic                     mainOneMatch,
  input  logic                     mainCmp0Match,
  input  logic                     countingDown,
  input  logic [SEL_W-1:0]         trigSel,
  input  logic [HALL_W*MODE_W-1:0] chanModes,
  output logic                     trigger
);
  logic [HALL_W-1:0] chanIsHall;
  logic              srcHit;

  // every channel field must select Hall sensor mode
  for (genvar i = 0; i < HALL_W; i++) begin : g_mode
    assign chanIsHall[i] = (chanModes[i*MODE_W +: MODE_W] == MODE_W'(HALL_MODE));
  end

  always_comb begin
    case (trigSel)
      3'd0: srcHit = hallEdge;
      3'd1: srcHit = auxCmpMatch;
      3'd2: srcHit = auxPeriodMatch;
      3'd3: srcHit = 1'b0;
      3'd4: srcHit = mainPeriodMatch && !countingDown;
      3'd5: srcHit = mainOneMatch && countingDown;
      3'd6: srcHit = mainCmp0Match && !countingDown;
      default: srcHit = mainCmp0Match && countingDown;
    endcase
  end

  assign trigger = srcHit && (&chanIsHall);
endmodule

// File: rtl/hst_ctrl.sv
module hst_ctrl
  import hst_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trigger,
  input  logic            delayBypass,
  input  logic [DT_W-1:0] deadTimeReload,
  output hstStrobes_t     strobes
);
  dtState_e        dtState;
  logic [DT_W-1:0] dtCount;
  logic            immediate;
  logic            loadNow;
  logic            expire;

  assign immediate = trigger && (delayBypass || deadTimeReload == '0);
  assign loadNow   = trigger && !immediate;
  assign expire    = (dtState == DT_COUNT) && !trigger && (dtCount == DT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dtState <= DT_IDLE;
      dtCount <= '0;
    end else if (loadNow) begin
      dtState <= DT_COUNT;
      dtCount <= deadTimeReload;
    end else if (immediate) begin
      dtState <= DT_IDLE;
      dtCount <= '0;
    end else if (dtState == DT_COUNT) begin
      dtCount <= dtCount - DT_W'(1);
      if (dtCount == DT_W'(1)) dtState <= DT_IDLE;
    end
  end

  always_comb begin
    strobes.capture = immediate || expire;
    strobes.delayed = expire;
  end
endmodule

// File: rtl/hst_datapath.sv
module hst_datapath
  import hst_pkg::*;
#(
  parameter int HALL_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALL_W-1:0] hallIn,
  input  hstStrobes_t       strobes,
  output logic              hallEdge,
  output logic              sampleStrobe,
  output logic [HALL_W-1:0] curPattern,
  output logic [HALL_W-1:0] lastPattern,
  output logic              patternChange
);
  logic [HALL_W-1:0] syncStage [SYNC_STAGES];
  logic [HALL_W-1:0] synced;
  logic [HALL_W-1:0] prevSynced;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) syncStage[s] <= '0;
        else     syncStage[s] <= hallIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) syncStage[s] <= '0;
        else     syncStage[s] <= syncStage[s-1];
      end
    end
  end

  assign synced   = syncStage[SYNC_STAGES-1];
  assign hallEdge = (synced != prevSynced);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevSynced    <= '0;
      sampleStrobe  <= 1'b0;
      curPattern    <= '0;
      lastPattern   <= '0;
      patternChange <= 1'b0;
    end else begin
      prevSynced    <= synced;
      sampleStrobe  <= strobes.capture;
      patternChange <= 1'b0;
      if (strobes.capture) begin
        curPattern    <= synced;
        lastPattern   <= curPattern;
        patternChange <= (synced != curPattern);
      end
    end
  end
endmodule

// File: rtl/hall_sample_trigger.sv
module hall_sample_trigger
  import hst_pkg::*;
#(
  parameter int HALL_W      = 3,
  parameter int MODE_W      = 4,
  parameter int SEL_W       = 3,
  parameter int DT_W        = 8,
  parameter int HALL_MODE   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int MODES_W    = HALL_W * MODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HALL_W-1:0]  hallIn,
  input  logic               auxCmpMatch,
  input  logic               auxPeriodMatch,
  input  logic               mainPeriodMatch,
  input  logic               mainOneMatch,
  input  logic               mainCmp0Match,
  input  logic               countingDown,
  input  logic [SEL_W-1:0]   trigSel,
  input  logic               delayBypass,
  input  logic [MODES_W-1:0] chanModes,
  input  logic [DT_W-1:0]    deadTimeReload,
  output logic               sampleStrobe,
  output logic [HALL_W-1:0]  curPattern,
  output logic [HALL_W-1:0]  lastPattern,
  output logic               patternChange
);
  logic        hallEdge;
  logic        trigger;
  hstStrobes_t strobes;

  hst_trig_select #(
    .HALL_W(HALL_W), .MODE_W(MODE_W), .SEL_W(SEL_W), .HALL_MODE(HALL_MODE)
  ) trigSel_i (
    .hallEdge(hallEdge), .auxCmpMatch(auxCmpMatch), .auxPeriodMatch(auxPeriodMatch),
    .mainPeriodMatch(mainPeriodMatch), .mainOneMatch(mainOneMatch),
    .mainCmp0Match(mainCmp0Match), .countingDown(countingDown),
    .trigSel(trigSel), .chanModes(chanModes), .trigger(trigger)
  );

  hst_ctrl #(.DT_W(DT_W)) ctrl_i (
    .clk(clk), .rst(rst), .trigger(trigger), .delayBypass(delayBypass),
    .deadTimeReload(deadTimeReload), .strobes(strobes)
  );

  hst_datapath #(.HALL_W(HALL_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rst(rst), .hallIn(hallIn), .strobes(strobes), .hallEdge(hallEdge),
    .sampleStrobe(sampleStrobe), .curPattern(curPattern),
    .lastPattern(lastPattern), .patternChange(patternChange)
  );
endmodule

// File: rtl/hst_checker.sv
module hst_checker #(
  parameter int HALL_W = 3,
  parameter int SEL_W  = 3,
  parameter int MODES_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               mainPeriodMatch,
  input logic               countingDown,
  input logic [SEL_W-1:0]   trigSel,
  input logic               delayBypass,
  input logic [MODES_W-1:0] chanModes,
  input logic               sampleStrobe,
  input logic [HALL_W-1:0]  curPattern,
  input logic [HALL_W-1:0]  lastPattern,
  input logic               patternChange
);
  logic allHall;
  assign allHall = (chanModes == {(MODES_W/4){4'd8}});

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sampleStrobe && !patternChange && curPattern == '0 && lastPattern == '0));

  // R11
  a_r11_change_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    patternChange |-> sampleStrobe);

  a_r11_flag_matches: assert property (@(posedge clk) disable iff (rst)
    sampleStrobe |-> (patternChange == (curPattern != lastPattern)));

  a_r11_last_follows: assert property (@(posedge clk) disable iff (rst)
    (sampleStrobe && $past(!rst)) |-> (lastPattern == $past(curPattern)));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!sampleStrobe && $past(!rst)) |-> ($stable(curPattern) && $stable(lastPattern)));

  // R8
  a_r8_bypass_next: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(delayBypass && allHall && trigSel == 3'd4 &&
                          mainPeriodMatch && !countingDown)) |-> sampleStrobe);
endmodule

bind hall_sample_trigger hst_checker #(
  .HALL_W(HALL_W), .SEL_W(SEL_W), .MODES_W(MODES_W)
) chk_i (.*);

// File: tb/hall_sample_trigger_tb_top.sv
module hall_sample_trigger_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] hallIn = '0;
  logic auxCmpMatch = 0, auxPeriodMatch = 0, mainPeriodMatch = 0;
  logic mainOneMatch = 0, mainCmp0Match = 0, countingDown = 0;
  logic [2:0] trigSel = '0;
  logic delayBypass = 1'b1;
  logic [11:0] chanModes = {3{4'd8}};
  logic [7:0] deadTimeReload = '0;
  logic sampleStrobe, patternChange;
  logic [2:0] curPattern, lastPattern;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { logic [2:0] cur; logic [2:0] last; logic chg; string req; } expItem_t;
  expItem_t expQ[$];
  logic [2:0] mCur = '0;

  always #10 clk = ~clk;

  hall_sample_trigger dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectSample(input logic [2:0] pat, input string req);
    expItem_t it;
    it.cur = pat; it.last = mCur; it.chg = (pat != mCur); it.req = req;
    expQ.push_back(it);
    mCur = pat;
  endtask

  // monitor: pops one expected item per observed strobe
  always @(negedge clk) begin
    if (!rst && sampleStrobe) begin
      if (expQ.size() == 0) begin
        check(0, "unexpected strobe", 1, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(curPattern == it.cur, it.req, curPattern, it.cur);
        check(lastPattern == it.last, it.req, lastPattern, it.last);
        check(patternChange == it.chg, it.req, patternChange, it.chg);
      end
    end
  end

  // 0 auxCmp 1 auxPeriod 2 mainPeriod 3 mainOne 4 mainCmp0
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: auxCmpMatch = 1; 1: auxPeriodMatch = 1; 2: mainPeriodMatch = 1;
      3: mainOneMatch = 1; default: mainCmp0Match = 1;
    endcase
    @(negedge clk);
    auxCmpMatch = 0; auxPeriodMatch = 0; mainPeriodMatch = 0;
    mainOneMatch = 0; mainCmp0Match = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setHall(input logic [2:0] v);
    @(negedge clk);
    hallIn = v;
    idle(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: events during reset leave nothing behind
    mainPeriodMatch = 1;
    trigSel = 3'd4;
    idle(3);
    mainPeriodMatch = 0;
    idle(1);
    check(!sampleStrobe && curPattern == 0 && lastPattern == 0 && !patternChange,
          "R1 reset state", curPattern, 0);
    rst = 0;
    idle(3);
    check(!sampleStrobe, "R1 no sample from reset-time event", sampleStrobe, 0);

    // R2/R8: Hall edge, bypass
    trigSel = 3'd0;
    expectSample(3'd5, "R2 hall edge sample");
    setHall(3'd5);

    // R3: one channel not in Hall mode
    chanModes = {4'd8, 4'd3, 4'd8};
    setHall(3'd2);
    check(curPattern == 3'd5, "R3 gated when not all Hall mode", curPattern, 5);
    chanModes = {3{4'd8}};

    // R2: with select 1 Hall change ignored; R4 aux compare
    trigSel = 3'd1;
    setHall(3'd6);
    check(curPattern == 3'd5, "R2 hall edge ignored with select 1", curPattern, 5);
    pulse(1);  // aux period under select 1: ignored
    idle(3);
    expectSample(3'd6, "R4 aux compare select 1");
    pulse(0);
    idle(3);
    trigSel = 3'd2;
    pulse(0);  // ignored
    idle(3);
    expectSample(3'd6, "R4 aux period select 2 same pattern");
    pulse(1);
    idle(3);

    // R5
    setHall(3'd1);
    trigSel = 3'd4;
    countingDown = 1; pulse(2); idle(3);
    countingDown = 0;
    expectSample(3'd1, "R5 period match up");
    pulse(2); idle(3);
    trigSel = 3'd5;
    pulse(3); idle(3);  // up: ignored
    countingDown = 1;
    setHall(3'd3);
    expectSample(3'd3, "R5 one match down");
    pulse(3); idle(3);

    // R6
    trigSel = 3'd6;
    pulse(4); idle(3);  // down: ignored
    countingDown = 0;
    setHall(3'd4);
    expectSample(3'd4, "R6 cmp0 up");
    pulse(4); idle(3);
    trigSel = 3'd7;
    pulse(4); idle(3);  // up: ignored
    countingDown = 1;
    setHall(3'd7);
    expectSample(3'd7, "R6 cmp0 down");
    pulse(4); idle(3);

    // R7: everything off
    trigSel = 3'd3;
    for (int w = 0; w < 5; w++) begin pulse(w); idle(2); end
    countingDown = 0;
    for (int w = 0; w < 5; w++) begin pulse(w); idle(2); end
    setHall(3'd2);
    check(curPattern == 3'd7, "R7 select 3 disables all", curPattern, 7);

    // R9: dead-time delay D = 5
    trigSel = 3'd1;
    delayBypass = 0;
    deadTimeReload = 8'd5;
    expectSample(3'd2, "R9 delayed sample");
    @(negedge clk); auxCmpMatch = 1;
    @(negedge clk); auxCmpMatch = 0;
    check(!sampleStrobe, "R8 no immediate strobe when delayed", sampleStrobe, 0);
    repeat (4) @(negedge clk);
    check(!sampleStrobe, "R9 strobe not early", sampleStrobe, 0);
    @(negedge clk);
    check(sampleStrobe, "R9 strobe after D cycles", sampleStrobe, 1);
    idle(3);

    // R10: retrigger restarts with D = 6
    deadTimeReload = 8'd6;
    setHall(3'd0);
    expectSample(3'd0, "R10 single sample after restart");
    @(negedge clk); auxCmpMatch = 1;
    @(negedge clk); auxCmpMatch = 0;
    idle(2);
    auxCmpMatch = 1;
    @(negedge clk); auxCmpMatch = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(!sampleStrobe, "R10 no strobe from first trigger", sampleStrobe, 0);
    end
    @(negedge clk);
    check(sampleStrobe, "R10 strobe timed from last trigger", sampleStrobe, 1);
    idle(3);

    // R9: D = 0 acts as bypass; R8 bypass timing
    deadTimeReload = 8'd0;
    setHall(3'd5);
    expectSample(3'd5, "R9 zero reload immediate");
    @(negedge clk); auxCmpMatch = 1;
    @(negedge clk); auxCmpMatch = 0;
    check(sampleStrobe, "R9 zero reload strobe next cycle", sampleStrobe, 1);
    idle(2);
    delayBypass = 1;
    deadTimeReload = 8'd9;
    expectSample(3'd5, "R8 bypass ignores reload");
    @(negedge clk); auxCmpMatch = 1;
    @(negedge clk); auxCmpMatch = 0;
    check(sampleStrobe, "R8 bypass strobe next cycle", sampleStrobe, 1);
    idle(4);

    check(expQ.size() == 0, "R11 all expected samples seen", expQ.size(), 0);

    // R1: reset mid-run
    rst = 1;
    idle(2);
    check(curPattern == 0 && lastPattern == 0 && !sampleStrobe, "R1 reset clears",
          curPattern, 0);
    rst = 0;
    idle(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule